// File: doc/BRIEF.md
# Registered Cascadable Multiplier

This block forms the complete product of an m-bit multiplicand and an n-bit multiplier, giving an (m+n)-bit result. A single mode input chooses between two's-complement and unsigned arithmetic. It adds nothing after the product, accumulates nothing, and neither rounds nor saturates.

Three register stages can each be kept or removed when the block is elaborated:

- an operand stage, which holds each operand and the mode bit;
- a pipeline stage after the multiplier;
- an output stage.

The latency is the number of stages kept, so it runs from zero to three cycles.

Each operand register takes its value either from the parallel operand port or from a cascade input. The register's contents are always driven out on a cascade output. Chaining instances therefore builds a tapped delay line of operands. Four clock/enable/reset sets arrive as 4-bit buses. Each register group uses the set named by its own domain parameter.

Top module: `chain_mult`

## Requirements
- R1: With `signed_i` = 0 both operands are zero-extended, and `product_o` is the unsigned product, A_W+B_W bits wide.
- R2: With `signed_i` = 1 both operands are two's complement, and `product_o` is the signed product, sign-extended to A_W+B_W bits.
- R3: With all stages kept (the default), an operand pair presented before clock edge k appears on `product_o` after edge k+2. In general the latency equals the number of stages kept.
- R4: With every stage removed, `product_o` follows the inputs combinationally, and each cascade output equals the selected operand source.
- R5: Each cascade output shows the value that its operand register loaded at the previous edge of its domain.
- R6: An instance whose operand source is set to the cascade inputs multiplies the values arriving from its neighbour's cascade outputs, one cycle later than that neighbour.
- R7: The mode bit passes through its own register in the operand stage, so each product uses the mode that was presented together with its operands.
- R8: While a register's clock enable is low, that register holds its value.
- R9: Reset is synchronous and takes priority over the clock enable. A register whose reset is high at an edge becomes zero.
- R10: Each register group obeys only its own domain. Holding the output domain freezes `product_o` while the earlier stages keep loading new operands.
- R11: The corner operands multiply correctly: most-negative times most-negative, minus one times minus one, and all-ones times all-ones unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_set_i | input | 4 | Clocks of the four domains |
| ce_set_i | input | 4 | Clock enables of the four domains |
| rst_set_i | input | 4 | Synchronous resets of the four domains |
| mcand_i | input | A_W | Parallel multiplicand |
| mplier_i | input | B_W | Parallel multiplier |
| mcand_shin_i | input | A_W | Multiplicand cascade input |
| mplier_shin_i | input | B_W | Multiplier cascade input |
| signed_i | input | 1 | 1 = two's complement, 0 = unsigned |
| mcand_shout_o | output | A_W | Registered multiplicand, for the next instance |
| mplier_shout_o | output | B_W | Registered multiplier, for the next instance |
| product_o | output | A_W+B_W | Product |

## Verification
The bench switches the mode bit on every cycle while the operands are negative. A design that fails to delay the mode bit alongside the operands gives unsigned results for signed pairs, and the reverse.

A second instance sources its operands from the first instance's cascade outputs. A cascade tapped before the register, or tapped one stage too late, shifts the products by a cycle.

The bench holds the output domain alone. A design that shares enables between groups either lets the output move or stalls the earlier stages, and the product that emerges afterwards is wrong. Reset is raised with every enable low. A design that gates reset with the enable keeps its stale values.

// File: rtl/chain_mult_pkg.sv
package chain_mult_pkg;
   localparam int NUM_DOM = 4;

   function automatic bit dom_ok(int d);
      return (d >= 0) && (d < NUM_DOM);
   endfunction
endpackage

// File: rtl/chain_mult_stage.sv
module chain_mult_stage #(
   parameter int W   = 8,
   parameter bit EN  = 1'b1
) (
   input  logic         clk_i,
   input  logic         ce_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (EN) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk_i) begin
            if (rst_i)     q_r <= '0;
            else if (ce_i) q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_thru
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/chain_mult_core.sv
module chain_mult_core #(
   parameter int A_W = 8,
   parameter int B_W = 6
) (
   input  logic [A_W-1:0]     a_i,
   input  logic [B_W-1:0]     b_i,
   input  logic               sgn_i,
   output logic [A_W+B_W-1:0] p_o
);
   localparam int P_W = A_W + B_W;

   logic signed [P_W-1:0] a_ext, b_ext, p_full;

   always_comb begin
      a_ext  = sgn_i ? {{B_W{a_i[A_W-1]}}, a_i} : {{B_W{1'b0}}, a_i};
      b_ext  = sgn_i ? {{A_W{b_i[B_W-1]}}, b_i} : {{A_W{1'b0}}, b_i};
      p_full = a_ext * b_ext;
   end

   assign p_o = p_full;
endmodule

// File: rtl/chain_mult.sv
module chain_mult
   import chain_mult_pkg::*;
#(
   parameter int A_W         = 8,
   parameter int B_W         = 6,
   parameter bit REG_A       = 1'b1,
   parameter bit REG_B       = 1'b1,
   parameter bit REG_SGN     = 1'b1,
   parameter bit REG_PIPE    = 1'b1,
   parameter bit REG_OUT     = 1'b1,
   parameter bit SRC_A_SHIFT = 1'b0,
   parameter bit SRC_B_SHIFT = 1'b0,
   parameter int DOM_A       = 0,
   parameter int DOM_B       = 1,
   parameter int DOM_SGN     = 0,
   parameter int DOM_PIPE    = 2,
   parameter int DOM_OUT     = 3
) (
   input  logic [NUM_DOM-1:0]   clk_set_i,
   input  logic [NUM_DOM-1:0]   ce_set_i,
   input  logic [NUM_DOM-1:0]   rst_set_i,
   input  logic [A_W-1:0]       mcand_i,
   input  logic [B_W-1:0]       mplier_i,
   input  logic [A_W-1:0]       mcand_shin_i,
   input  logic [B_W-1:0]       mplier_shin_i,
   input  logic                 signed_i,
   output logic [A_W-1:0]       mcand_shout_o,
   output logic [B_W-1:0]       mplier_shout_o,
   output logic [A_W+B_W-1:0]   product_o
);
   localparam int P_W = A_W + B_W;

   // elaboration-time parameter checks
   generate
      if (A_W < 2 || B_W < 2) begin : g_bad_width
         $error("chain_mult: operand widths must be at least 2");
      end
      if (!dom_ok(DOM_A) || !dom_ok(DOM_B) || !dom_ok(DOM_SGN) ||
          !dom_ok(DOM_PIPE) || !dom_ok(DOM_OUT)) begin : g_bad_dom
         $error("chain_mult: domain index out of range");
      end
      if (REG_SGN != (REG_A || REG_B)) begin : g_bad_sgn
         $error("chain_mult: mode register must match operand stage");
      end
   endgenerate

   logic [A_W-1:0] a_src, a_q;
   logic [B_W-1:0] b_src, b_q;
   logic           s_q;
   logic [P_W-1:0] p_raw, p_pipe;

   generate
      if (SRC_A_SHIFT) begin : g_a_shift
         assign a_src = mcand_shin_i;
      end else begin : g_a_par
         assign a_src = mcand_i;
      end
      if (SRC_B_SHIFT) begin : g_b_shift
         assign b_src = mplier_shin_i;
      end else begin : g_b_par
         assign b_src = mplier_i;
      end
   endgenerate

   chain_mult_stage #(.W(A_W), .EN(REG_A)) u_a_reg (
      .clk_i(clk_set_i[DOM_A]), .ce_i(ce_set_i[DOM_A]), .rst_i(rst_set_i[DOM_A]),
      .d_i(a_src), .q_o(a_q));

   chain_mult_stage #(.W(B_W), .EN(REG_B)) u_b_reg (
      .clk_i(clk_set_i[DOM_B]), .ce_i(ce_set_i[DOM_B]), .rst_i(rst_set_i[DOM_B]),
      .d_i(b_src), .q_o(b_q));

   chain_mult_stage #(.W(1), .EN(REG_SGN)) u_sgn_reg (
      .clk_i(clk_set_i[DOM_SGN]), .ce_i(ce_set_i[DOM_SGN]), .rst_i(rst_set_i[DOM_SGN]),
      .d_i(signed_i), .q_o(s_q));

   assign mcand_shout_o  = a_q;
   assign mplier_shout_o = b_q;

   chain_mult_core #(.A_W(A_W), .B_W(B_W)) u_core (
      .a_i(a_q), .b_i(b_q), .sgn_i(s_q), .p_o(p_raw));

   chain_mult_stage #(.W(P_W), .EN(REG_PIPE)) u_pipe_reg (
      .clk_i(clk_set_i[DOM_PIPE]), .ce_i(ce_set_i[DOM_PIPE]), .rst_i(rst_set_i[DOM_PIPE]),
      .d_i(p_raw), .q_o(p_pipe));

   chain_mult_stage #(.W(P_W), .EN(REG_OUT)) u_out_reg (
      .clk_i(clk_set_i[DOM_OUT]), .ce_i(ce_set_i[DOM_OUT]), .rst_i(rst_set_i[DOM_OUT]),
      .d_i(p_pipe), .q_o(product_o));
endmodule

// File: rtl/chain_mult_chk.sv
module chain_mult_chk #(
   parameter int A_W         = 8,
   parameter int B_W         = 6,
   parameter bit REG_A       = 1'b1,
   parameter bit REG_B       = 1'b1,
   parameter bit REG_OUT     = 1'b1,
   parameter bit SRC_A_SHIFT = 1'b0,
   parameter bit SRC_B_SHIFT = 1'b0,
   parameter int DOM_A       = 0,
   parameter int DOM_B       = 1,
   parameter int DOM_OUT     = 3
) (
   input logic [3:0]         clk_set_i,
   input logic [3:0]         ce_set_i,
   input logic [3:0]         rst_set_i,
   input logic [A_W-1:0]     mcand_i,
   input logic [B_W-1:0]     mplier_i,
   input logic [A_W-1:0]     mcand_shin_i,
   input logic [B_W-1:0]     mplier_shin_i,
   input logic               signed_i,
   input logic [A_W-1:0]     mcand_shout_o,
   input logic [B_W-1:0]     mplier_shout_o,
   input logic [A_W+B_W-1:0] product_o
);
   logic [A_W-1:0] a_sel;
   logic [B_W-1:0] b_sel;
   assign a_sel = SRC_A_SHIFT ? mcand_shin_i  : mcand_i;
   assign b_sel = SRC_B_SHIFT ? mplier_shin_i : mplier_i;

   generate
      if (REG_OUT) begin : g_out
         a_r8_out_hold: assert property (@(posedge clk_set_i[DOM_OUT])
            disable iff (rst_set_i[DOM_OUT])
            !ce_set_i[DOM_OUT] |=> $stable(product_o));
      end
      if (REG_A) begin : g_a
         a_r5_a_load: assert property (@(posedge clk_set_i[DOM_A])
            disable iff (rst_set_i[DOM_A])
            ce_set_i[DOM_A] |=> mcand_shout_o == $past(a_sel));
         a_r8_a_hold: assert property (@(posedge clk_set_i[DOM_A])
            disable iff (rst_set_i[DOM_A])
            !ce_set_i[DOM_A] |=> $stable(mcand_shout_o));
      end
      if (REG_B) begin : g_b
         a_r5_b_load: assert property (@(posedge clk_set_i[DOM_B])
            disable iff (rst_set_i[DOM_B])
            ce_set_i[DOM_B] |=> mplier_shout_o == $past(b_sel));
         a_r8_b_hold: assert property (@(posedge clk_set_i[DOM_B])
            disable iff (rst_set_i[DOM_B])
            !ce_set_i[DOM_B] |=> $stable(mplier_shout_o));
      end
   endgenerate
endmodule

bind chain_mult chain_mult_chk #(
   .A_W(A_W), .B_W(B_W), .REG_A(REG_A), .REG_B(REG_B), .REG_OUT(REG_OUT),
   .SRC_A_SHIFT(SRC_A_SHIFT), .SRC_B_SHIFT(SRC_B_SHIFT),
   .DOM_A(DOM_A), .DOM_B(DOM_B), .DOM_OUT(DOM_OUT)
) u_chk (.*);

// File: tb/test_chain_mult.sv
`timescale 1ns/1ps
module test_chain_mult;
   localparam int AW = 8;
   localparam int BW = 6;
   localparam int PW = AW + BW;

   logic          clk = 1'b0;
   logic [3:0]    ce, rst;
   logic [AW-1:0] a;
   logic [BW-1:0] b;
   logic          s;
   logic [AW-1:0] a_so, t_a_so, c_a_so;
   logic [BW-1:0] b_so, t_b_so, c_b_so;
   logic [PW-1:0] prod, t_prod, c_prod;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // main instance: all stages kept, parallel sources
   chain_mult #(.A_W(AW), .B_W(BW)) i_chain_mult (
      .clk_set_i({4{clk}}), .ce_set_i(ce), .rst_set_i(rst),
      .mcand_i(a), .mplier_i(b), .mcand_shin_i('0), .mplier_shin_i('0),
      .signed_i(s), .mcand_shout_o(a_so), .mplier_shout_o(b_so), .product_o(prod));

   // tap instance: operands from the main instance's cascade outputs
   chain_mult #(.A_W(AW), .B_W(BW), .REG_PIPE(1'b0), .REG_OUT(1'b0),
                .SRC_A_SHIFT(1'b1), .SRC_B_SHIFT(1'b1),
                .DOM_A(0), .DOM_B(0), .DOM_SGN(0), .DOM_PIPE(0), .DOM_OUT(0)) i_chain_mult_tap (
      .clk_set_i({4{clk}}), .ce_set_i(ce), .rst_set_i(rst),
      .mcand_i('0), .mplier_i('0), .mcand_shin_i(a_so), .mplier_shin_i(b_so),
      .signed_i(1'b1), .mcand_shout_o(t_a_so), .mplier_shout_o(t_b_so), .product_o(t_prod));

   // combinational instance: every stage removed
   chain_mult #(.A_W(AW), .B_W(BW), .REG_A(1'b0), .REG_B(1'b0), .REG_SGN(1'b0),
                .REG_PIPE(1'b0), .REG_OUT(1'b0)) i_chain_mult_comb (
      .clk_set_i({4{clk}}), .ce_set_i(ce), .rst_set_i(rst),
      .mcand_i(a), .mplier_i(b), .mcand_shin_i('0), .mplier_shin_i('0),
      .signed_i(s), .mcand_shout_o(c_a_so), .mplier_shout_o(c_b_so), .product_o(c_prod));

   function automatic logic [PW-1:0] ref_mul(logic [AW-1:0] x, logic [BW-1:0] y, logic sg);
      longint xv, yv;
      if (sg) begin
         xv = longint'($signed(x));
         yv = longint'($signed(y));
      end else begin
         xv = longint'(x);
         yv = longint'(y);
      end
      return PW'(xv * yv);
   endfunction

   task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // scoreboard queues
   logic [PW-1:0] m_val[$];
   int            m_due[$];
   string         m_tag[$];
   logic [PW-1:0] t_val[$];
   int            t_due[$];

   // monitor
   always @(negedge clk) begin
      while (m_due.size() > 0 && m_due[0] == cyc) begin
         chk({m_tag[0], " R3 R7"}, prod, m_val[0]);
         void'(m_due.pop_front()); void'(m_val.pop_front()); void'(m_tag.pop_front());
      end
      while (t_due.size() > 0 && t_due[0] == cyc) begin
         chk("R6", t_prod, t_val[0]);
         void'(t_due.pop_front()); void'(t_val.pop_front());
      end
   end

   logic [AW-1:0] pa;
   logic [BW-1:0] pb;
   bit            pvalid = 1'b0;

   // driver: called right after a falling edge
   task automatic drive(logic [AW-1:0] av, logic [BW-1:0] bv, logic sv, string tag);
      if (pvalid) begin
         chk("R5 a", PW'(a_so), PW'(pa));
         chk("R5 b", PW'(b_so), PW'(pb));
      end
      a = av; b = bv; s = sv;
      pa = av; pb = bv; pvalid = 1'b1;
      m_val.push_back(ref_mul(av, bv, sv)); m_due.push_back(cyc + 3); m_tag.push_back(tag);
      t_val.push_back(ref_mul(av, bv, 1'b1)); t_due.push_back(cyc + 2);
      #1;
      chk("R4 product", c_prod, ref_mul(av, bv, sv));
      chk("R4 cascade", PW'(c_a_so), PW'(av));
   endtask

   initial begin
      logic [PW-1:0] p0, t0;
      logic [AW-1:0] a0;
      logic [BW-1:0] b0;
      ce = 4'hF; rst = 4'hF; a = 8'h5A; b = 6'h15; s = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 reset product", prod, '0);
      chk("R9 reset cascade", PW'({a_so, b_so}), '0);
      chk("R9 reset tap", t_prod, '0);
      rst = 4'h0;

      // directed corners and mode alternation
      @(negedge clk); drive(8'h80, 6'h20, 1'b1, "R11 R2");
      @(negedge clk); drive(8'hFF, 6'h3F, 1'b0, "R11 R1");
      @(negedge clk); drive(8'hFF, 6'h3F, 1'b1, "R11 R2");
      @(negedge clk); drive(8'h7F, 6'h1F, 1'b1, "R2");
      @(negedge clk); drive(8'h80, 6'h1F, 1'b0, "R1");
      @(negedge clk); drive(8'h00, 6'h3A, 1'b1, "R2");
      @(negedge clk); drive(8'h80, 6'h20, 1'b0, "R11 R1");
      for (int i = 0; i < 40; i++) begin
         logic sv;
         sv = 1'(i);
         @(negedge clk);
         drive(8'($urandom), 6'($urandom), sv, sv ? "R2" : "R1");
      end
      repeat (5) @(negedge clk);
      pvalid = 1'b0;

      // R8: all enables low, inputs move, everything holds
      p0 = prod; t0 = t_prod; a0 = a_so; b0 = b_so;
      ce = 4'h0;
      for (int i = 0; i < 3; i++) begin
         a = 8'(8'h11 * (i + 3)); b = 6'(6'h0B * (i + 1)); s = ~s;
         @(negedge clk);
         chk("R8 product", prod, p0);
         chk("R8 tap", t_prod, t0);
         chk("R8 cascade", PW'({a_so, b_so}), PW'({a0, b0}));
      end

      // R10: only the output domain held
      ce = 4'b0111; a = 8'h9C; b = 6'h2B; s = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R10 output held", prod, p0);
      end
      chk("R10 earlier stages advanced", PW'(a_so), PW'(8'h9C));
      ce = 4'hF;
      @(negedge clk);
      chk("R10 output released", prod, ref_mul(8'h9C, 6'h2B, 1'b1));

      // R9: reset wins over a low enable
      ce = 4'h0; rst = 4'hF;
      @(negedge clk);
      chk("R9 reset over hold product", prod, '0);
      chk("R9 reset over hold cascade", PW'({a_so, b_so}), '0);
      chk("R9 reset over hold tap", t_prod, '0);
      rst = 4'h0; ce = 4'hF;

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule